// File: doc/BRIEF.md
# Shared Byte FIFO with Watermark Flags

This block is a byte buffer that two agents share. A host reaches it through a single data register: each write pushes one byte, and each read pops the oldest byte. An internal engine has its own port into the same storage. For example, a receive path can push bytes into it and a transmit path can pop bytes from it. Both read ports always present the same head byte.

The block keeps a fill count from 0 to the depth. It derives two level flags from that count and a programmable water level. The high flag warns that little free space is left. The low flag warns that few bytes are left to read. A sticky overflow flag records any push that arrived while the buffer was full. A one-cycle flush empties the buffer and clears that flag.

Top module: `byte_fifo_wm`

## Requirements
- R1: After reset the fill count is 0, the overflow flag is 0, both read ports return 0x00, and the low flag is 1.
- R2: Each accepted push raises the fill count by one and each accepted pop lowers it by one. Bytes leave in the order they entered, and the head byte appears on the read data output while the count is non-zero.
- R3: The high flag is 1 exactly when (DEPTH − fill count) ≤ water level. With DEPTH 64 and level 4, a count of 60 gives 1 and a count of 59 gives 0. With level 0, a full buffer gives 1.
- R4: The low flag is 1 exactly when fill count ≤ water level. With level 4, a count of 4 gives 1 and a count of 5 gives 0.
- R5: A push from either port while the count equals DEPTH is discarded and sets the overflow flag. The flag then stays 1 through later pops until a flush.
- R6: Flush sets the fill count to 0 and clears the overflow flag in the cycle it is sampled. A push or pop in the same cycle is dropped. The next push lands at the head.
- R7: A pop while the count is 0 has no effect on the count or the stored contents, and both read ports return 0x00.
- R8: When both ports push in one cycle, only the engine byte is stored. The host byte is dropped without setting the overflow flag unless the buffer is full.
- R9: A push and a pop in the same cycle on a non-empty, non-full buffer leave the count unchanged and advance the head.
- R10: When both ports pop in the same cycle, exactly one byte is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the buffer and clear the overflow flag |
| water_level | input | LW (6) | Threshold shared by both level flags |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | W (8) | Host push byte |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | W (8) | Head byte seen by the host, 0x00 when empty |
| eng_wr | input | 1 | Engine push strobe |
| eng_wdata | input | W (8) | Engine push byte |
| eng_rd | input | 1 | Engine pop strobe |
| eng_rdata | output | W (8) | Head byte seen by the engine, 0x00 when empty |
| fill_count | output | CW (7) | Number of stored bytes, 0 to DEPTH |
| hi_alert | output | 1 | Free space at or below the water level |
| lo_alert | output | 1 | Fill count at or below the water level |
| overflow | output | 1 | Sticky record of a push while full |

## Verification
The storage path is tested three ways: host-only pushes and pops, engine-only pops, and mixed traffic with a push and a pop in the same cycle. Together these separate an ordering fault from a counting fault. Both flag thresholds are swept by filling one byte at a time on each side of the level. The sweep is run at levels 4, 0 and 63, which exposes off-by-one and free-space-versus-count mix-ups. Collisions are also driven: dual pushes, dual pops, and a push or pop in the flush cycle. These show whether priority and drop rules are followed rather than both requests being served.

// File: rtl/byte_fifo_wm_pkg.sv
package byte_fifo_wm_pkg;

    // Which port, if any, owns the storage write in a cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOST = 2'd1,
        SRC_ENG  = 2'd2
    } wr_src_e;

    // Next position in a circular buffer of the given depth.
    function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
    import byte_fifo_wm_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          host_wr,
    input  logic          eng_wr,
    input  logic          host_rd,
    input  logic          eng_rd,
    output wr_src_e       wr_src,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          ovf
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
    } ctrl_state_t;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    ctrl_state_t st_d, st_q;
    logic        full;
    logic        want_wr;
    logic        want_rd;
    logic        do_push;
    logic        do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.count == FULL_CNT);
        want_wr = host_wr | eng_wr;
        want_rd = host_rd | eng_rd;
        do_push = want_wr & ~full & ~flush;
        do_pop  = want_rd & (st_q.count != '0) & ~flush;

        // engine wins a write collision; the host byte is dropped
        if (!do_push) begin
            wr_src = SRC_NONE;
        end else if (eng_wr) begin
            wr_src = SRC_ENG;
        end else begin
            wr_src = SRC_HOST;
        end

        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
            st_d.ovf    = 1'b0;
        end else begin
            if (do_push) begin
                st_d.wr_ptr = AW'(ring_next(int'(st_q.wr_ptr), DEPTH));
            end
            if (do_pop) begin
                st_d.rd_ptr = AW'(ring_next(int'(st_q.rd_ptr), DEPTH));
            end
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
            if (want_wr && full) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr = st_q.wr_ptr;
    assign rd_addr = st_q.rd_ptr;
    assign count   = st_q.count;
    assign empty   = (st_q.count == '0);
    assign ovf     = st_q.ovf;

endmodule

// File: rtl/byte_fifo_levels.sv
module byte_fifo_levels #(
    parameter int DEPTH = 64,
    parameter int LW    = 6,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int MW   = ((CW > LW) ? CW : LW) + 1
) (
    input  logic [CW-1:0] count,
    input  logic [LW-1:0] level,
    output logic          hi,
    output logic          lo
);

    logic [MW-1:0] free_w;
    logic [MW-1:0] cnt_w;
    logic [MW-1:0] lvl_w;

    always_comb begin
        cnt_w  = MW'(count);
        lvl_w  = MW'(level);
        free_w = MW'(DEPTH) - cnt_w;
        hi     = (free_w <= lvl_w);
        lo     = (cnt_w <= lvl_w);
    end

endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm
    import byte_fifo_wm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int LW    = 6,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [LW-1:0] water_level,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    input  logic          eng_wr,
    input  logic [W-1:0]  eng_wdata,
    input  logic          eng_rd,
    output logic [W-1:0]  eng_rdata,
    output logic [CW-1:0] fill_count,
    output logic          hi_alert,
    output logic          lo_alert,
    output logic          overflow
);

    wr_src_e       wr_src;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          empty;
    logic [W-1:0]  wr_byte;
    logic [W-1:0]  head_byte;
    logic [W-1:0]  shown_byte;

    byte_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .host_wr (host_wr),
        .eng_wr  (eng_wr),
        .host_rd (host_rd),
        .eng_rd  (eng_rd),
        .wr_src  (wr_src),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .count   (fill_count),
        .empty   (empty),
        .ovf     (overflow)
    );

    always_comb begin
        wr_byte = (wr_src == SRC_ENG) ? eng_wdata : host_wdata;
    end

    byte_fifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .we    (wr_src != SRC_NONE),
        .waddr (wr_addr),
        .wdata (wr_byte),
        .raddr (rd_addr),
        .rdata (head_byte)
    );

    byte_fifo_levels #(.DEPTH(DEPTH), .LW(LW)) u_levels (
        .count (fill_count),
        .level (water_level),
        .hi    (hi_alert),
        .lo    (lo_alert)
    );

    assign shown_byte = empty ? '0 : head_byte;
    assign host_rdata = shown_byte;
    assign eng_rdata  = shown_byte;

endmodule

// File: rtl/byte_fifo_wm_chk.sv
module byte_fifo_wm_chk #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int LW    = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic [LW-1:0] water_level,
    input logic          host_wr,
    input logic [W-1:0]  host_wdata,
    input logic          host_rd,
    input logic [W-1:0]  host_rdata,
    input logic          eng_wr,
    input logic [W-1:0]  eng_wdata,
    input logic          eng_rd,
    input logic [W-1:0]  eng_rdata,
    input logic [CW-1:0] fill_count,
    input logic          hi_alert,
    input logic          lo_alert,
    input logic          overflow
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_CNT);

    // R3
    full_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == FULL_CNT) |-> hi_alert);

    // R4
    empty_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> lo_alert);

    // R5
    no_overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count == FULL_CNT) && (host_wr || eng_wr) && !flush) |=> overflow);

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((fill_count == '0) && !overflow));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count == '0) && !host_wr && !eng_wr) |=> (fill_count == '0));

    // R7
    empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> ((host_rdata == '0) && (eng_rdata == '0)));

    // R9
    push_pop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count != '0) && (fill_count != FULL_CNT) && !flush
         && (host_wr || eng_wr) && (host_rd || eng_rd)) |=> $stable(fill_count));

    // R10
    dual_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_count != '0) && !flush && !host_wr && !eng_wr && host_rd && eng_rd)
        |=> (fill_count == $past(fill_count) - 1'b1));

endmodule

bind byte_fifo_wm byte_fifo_wm_chk #(.DEPTH(DEPTH), .W(W), .LW(LW)) u_chk (.*);

// File: tb/tb_byte_fifo_wm.sv
module tb_byte_fifo_wm;

    localparam int DEPTH = 64;
    localparam int W     = 8;
    localparam int LW    = 6;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [LW-1:0] water_level = 6'd4;
    logic          host_wr = 1'b0;
    logic [W-1:0]  host_wdata = '0;
    logic          host_rd = 1'b0;
    logic [W-1:0]  host_rdata;
    logic          eng_wr = 1'b0;
    logic [W-1:0]  eng_wdata = '0;
    logic          eng_rd = 1'b0;
    logic [W-1:0]  eng_rdata;
    logic [CW-1:0] fill_count;
    logic          hi_alert;
    logic          lo_alert;
    logic          overflow;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    byte_fifo_wm #(.DEPTH(DEPTH), .W(W), .LW(LW)) dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // one clock: inputs are held over the edge, then strobes drop
    task automatic tick();
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        eng_wr  = 1'b0;
        host_rd = 1'b0;
        eng_rd  = 1'b0;
        flush   = 1'b0;
    endtask

    task automatic hpush(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; tick();
    endtask

    task automatic hpop();
        host_rd = 1'b1; tick();
    endtask

    task automatic do_flush();
        flush = 1'b1; tick();
    endtask

    task automatic t_reset();
        check("R1 count", int'(fill_count), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 host data", int'(host_rdata), 0);
        check("R1 eng data", int'(eng_rdata), 0);
        check("R1 lo flag", int'(lo_alert), 1);
        check("R1 hi flag", int'(hi_alert), 0);
    endtask

    task automatic t_order();
        do_flush();
        hpush(8'hA1); hpush(8'hB2); hpush(8'hC3);
        check("R2 count after 3 pushes", int'(fill_count), 3);
        check("R2 head", int'(host_rdata), 'hA1);
        hpop();
        check("R2 count after pop", int'(fill_count), 2);
        check("R2 second byte", int'(host_rdata), 'hB2);
        eng_rd = 1'b1; tick();
        check("R2 engine pop count", int'(fill_count), 1);
        check("R2 engine head", int'(eng_rdata), 'hC3);
        check("R2 host sees same head", int'(host_rdata), 'hC3);
        hpop();
        check("R2 drained", int'(fill_count), 0);
    endtask

    task automatic t_empty_pop();
        do_flush();
        host_rd = 1'b1; eng_rd = 1'b1; tick();
        check("R7 count stays 0", int'(fill_count), 0);
        check("R7 data 0x00", int'(host_rdata), 0);
        hpush(8'h77);
        check("R7 push after empty pop count", int'(fill_count), 1);
        check("R7 head intact", int'(host_rdata), 'h77);
    endtask

    task automatic t_levels();
        do_flush();
        water_level = 6'd4;
        for (int i = 0; i < 4; i++) hpush(8'(i));
        check("R4 lo at count 4 level 4", int'(lo_alert), 1);
        hpush(8'h04);
        check("R4 lo at count 5 level 4", int'(lo_alert), 0);
        for (int i = 5; i < 59; i++) hpush(8'(i));
        check("R3 count 59", int'(fill_count), 59);
        check("R3 hi at count 59 level 4", int'(hi_alert), 0);
        hpush(8'd59);
        check("R3 hi at count 60 level 4", int'(hi_alert), 1);
        water_level = 6'd63;
        #1;
        check("R3 hi at count 60 level 63", int'(hi_alert), 1);
        check("R4 lo at count 60 level 63", int'(lo_alert), 1);
        do_flush();
        hpush(8'h01);
        check("R3 hi at count 1 level 63", int'(hi_alert), 1);
        water_level = 6'd0;
        #1;
        check("R3 hi at count 1 level 0", int'(hi_alert), 0);
        check("R4 lo at count 1 level 0", int'(lo_alert), 0);
        water_level = 6'd4;
        do_flush();
    endtask

    task automatic t_full();
        do_flush();
        water_level = 6'd0;
        for (int i = 0; i < DEPTH; i++) hpush(8'(8'h40 + i));
        check("R5 full count", int'(fill_count), DEPTH);
        check("R3 hi full level 0", int'(hi_alert), 1);
        check("R5 no overflow yet", int'(overflow), 0);
        hpush(8'hEE);
        check("R5 overflow after host push", int'(overflow), 1);
        check("R5 count held", int'(fill_count), DEPTH);
        check("R5 head unchanged", int'(host_rdata), 'h40);
        hpop();
        check("R5 sticky after pop", int'(overflow), 1);
        check("R5 head after pop", int'(host_rdata), 'h41);
        hpush(8'hEE);
        check("R5 refill count", int'(fill_count), DEPTH);
        eng_wr = 1'b1; eng_wdata = 8'hDD; tick();
        check("R5 engine push full count", int'(fill_count), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) hpop();
        check("R5 last byte is host refill", int'(host_rdata), 'hEE);
        water_level = 6'd4;
    endtask

    task automatic t_flush();
        hpush(8'h12);
        do_flush();
        check("R6 flush count", int'(fill_count), 0);
        check("R6 flush clears overflow", int'(overflow), 0);
        hpush(8'h34);
        check("R6 push after flush", int'(fill_count), 1);
        check("R6 head after flush", int'(host_rdata), 'h34);
        flush = 1'b1; host_wr = 1'b1; host_wdata = 8'h56; tick();
        check("R6 push in flush cycle dropped", int'(fill_count), 0);
        check("R6 data after dropped push", int'(host_rdata), 0);
    endtask

    task automatic t_priority();
        do_flush();
        host_wr = 1'b1; host_wdata = 8'h11;
        eng_wr = 1'b1; eng_wdata = 8'h22; tick();
        check("R8 one byte stored", int'(fill_count), 1);
        check("R8 engine byte wins", int'(host_rdata), 'h22);
        check("R8 no overflow when not full", int'(overflow), 0);
    endtask

    task automatic t_push_pop();
        do_flush();
        hpush(8'h10); hpush(8'h20);
        host_wr = 1'b1; host_wdata = 8'h30; eng_rd = 1'b1; tick();
        check("R9 count unchanged", int'(fill_count), 2);
        check("R9 head advanced", int'(host_rdata), 'h20);
        host_rd = 1'b1; eng_rd = 1'b1; tick();
        check("R10 dual pop removes one", int'(fill_count), 1);
        check("R10 next head", int'(eng_rdata), 'h30);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_order();
        t_empty_pop();
        t_levels();
        t_full();
        t_flush();
        t_priority();
        t_push_pop();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule